// File: doc/BRIEF.md
# Vector Early-Source Interlock Detector

This block sits at the issue stage of a vector unit. It compares each packet that is about to issue with the packet that issued just before it. From that comparison it decides whether one bubble cycle has to be inserted. Each source operand of the packet arrives as three fields:

- a vector register number;
- a pair flag, set when the operand names a register pair;
- a role code, which says whether the operand feeds a long-pipeline input, is an accumulator, or is an ordinary read.

The packet also supplies a 32-bit mask of the vector registers it writes. The block keeps that mask as the "written last packet" set once the packet actually issues.

Two rules produce a stall, and the second is the inverse of a normal hazard check:

- **Early-source rule.** A long-pipeline ("early") source stalls when the previous packet wrote its register.
- **Accumulator-order rule.** The accumulator of a three-vector-source accumulate stalls when the previous packet did *not* write it.

A stalled packet is held at the inputs for one more cycle and then issues without further delay. Two separate reason outputs let event counters tell the two kinds of stall apart. Scalar operands are simply not presented to the block, so they can never stall.

Top module: `vhz_interlock`

## Requirements
- R1: After synchronous reset the written-last-packet set is empty and no recovery is pending. An early source issued first does not stall, and a three-source accumulator issued first does stall.
- R2: An operand with role code 2 (early source) raises `stall_o` and `why_early_o` when any register it covers is in the set written by the previously issued packet.
- R3: Operands with role code 0 (unused), 1 (ordinary read), 3 (plain accumulator) or 5 to 7 never cause a stall, whether or not their register was written last packet.
- R4: The set is replaced by `dst_mask_i` on every cycle in which a packet issues without a stall. A packet between producer and early consumer that does not rewrite the register therefore removes the stall.
- R5: An operand with role code 4 (three-source accumulator) raises `stall_o` and `why_acc_o` when any register it covers was not written by the previously issued packet.
- R6: A three-source accumulator whose registers were all written by the previous packet does not stall, whatever value was written (a constant zero included).
- R7: With the pair flag set, an operand covers registers 2k and 2k+1, where k is its register number shifted right by one. Otherwise it covers only its own register.
- R8: A stall lasts exactly one cycle. The held packet issues on the next cycle without a stall, and the stall cycle leaves the set unchanged.
- R9: When both rules hit in one packet, `why_early_o` and `why_acc_o` are both high together with `stall_o`.
- R10: A cycle with `issue_valid_i` low counts as an empty packet. It clears the set, and all outputs stay low during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid_i | input | 1 | A packet is presented for issue this cycle |
| src_idx_i | input | NUM_SRC*5 | Vector register number of each source operand |
| src_pair_i | input | NUM_SRC | Operand names a register pair |
| src_role_i | input | NUM_SRC*3 | Role code of each operand (0 unused, 1 ordinary, 2 early, 3 accumulator, 4 three-source accumulator) |
| dst_mask_i | input | 32 | Vector registers written by the presented packet |
| stall_o | output | 1 | Insert one bubble; the packet must be held |
| why_early_o | output | 1 | Stall caused by an early-source hit |
| why_acc_o | output | 1 | Stall caused by accumulator-order miss |

## Verification
The embedded assertions watch the stored write set and the stall sequence on every cycle:

- a stall is never followed by a second stall;
- a stall cycle keeps the set stable;
- an idle cycle empties the set;
- each clean issue records its destination mask;
- no reason is raised without a packet.

Whether the correct operand roles and pair coverage decide the stall can only be shown by the bench's scenarios. The bench sweeps every writer register against every operand register, role code and pair setting. It also runs directed sequences for intervening packets, idle cycles, constant-zeroed accumulators and double-reason packets.

// File: rtl/vhz_pkg.sv
package vhz_pkg;

    localparam int VREGS  = 32;
    localparam int REG_W  = $clog2(VREGS);
    localparam int ROLE_W = 3;

    typedef logic [VREGS-1:0] vmask_t;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_NONE  = 3'd0,
        ROLE_ORD   = 3'd1,
        ROLE_EARLY = 3'd2,
        ROLE_ACC   = 3'd3,
        ROLE_ACC3  = 3'd4
    } src_role_e;

    typedef struct packed {
        logic [REG_W-1:0] idx;
        logic             pair;
        src_role_e        role;
    } src_op_t;

    typedef struct packed {
        logic early;
        logic acc;
    } stall_why_t;

    // Registers touched by one operand; a pair covers its even/odd members.
    function automatic vmask_t reg_cover(input logic [REG_W-1:0] idx, input logic pair);
        vmask_t m;
        m = '0;
        if (pair) begin
            m[{idx[REG_W-1:1], 1'b0}] = 1'b1;
            m[{idx[REG_W-1:1], 1'b1}] = 1'b1;
        end else begin
            m[idx] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/vhz_src_decode.sv
module vhz_src_decode
    import vhz_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  src_op_t [NUM_SRC-1:0] ops_i,
    output vmask_t                early_need_o,
    output vmask_t                acc3_need_o
);

    vmask_t early_per [NUM_SRC];
    vmask_t acc3_per  [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
        vmask_t cov;
        assign cov = reg_cover(ops_i[g].idx, ops_i[g].pair);
        always_comb begin
            early_per[g] = '0;
            acc3_per[g]  = '0;
            unique case (ops_i[g].role)
                ROLE_EARLY: early_per[g] = cov;
                ROLE_ACC3:  acc3_per[g]  = cov;
                default:    ;
            endcase
        end
    end

    always_comb begin
        early_need_o = '0;
        acc3_need_o  = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            early_need_o = early_need_o | early_per[k];
            acc3_need_o  = acc3_need_o  | acc3_per[k];
        end
    end

endmodule

// File: rtl/vhz_hazard_eval.sv
module vhz_hazard_eval
    import vhz_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       issue_valid_i,
    input  logic       recovering_i,
    input  vmask_t     early_need_i,
    input  vmask_t     acc3_need_i,
    input  vmask_t     prev_mask_i,
    output stall_why_t why_o
);

    logic early_hit;
    logic acc_miss;
    logic armed;

    assign early_hit = |(early_need_i & prev_mask_i);
    assign acc_miss  = |(acc3_need_i & ~prev_mask_i);
    assign armed     = issue_valid_i & ~recovering_i;

    always_comb begin
        why_o.early = armed & early_hit;
        why_o.acc   = armed & acc_miss;
    end

    // R10: no reason may be reported in a cycle without a packet
    p_reason_needs_issue_r10: assert property (@(posedge clk) disable iff (rst)
        (why_o.early || why_o.acc) |-> issue_valid_i);

    // R6: an accumulator set fully covered by last packet's writes never stalls
    p_acc_satisfied_r6: assert property (@(posedge clk) disable iff (rst)
        ((acc3_need_i & ~prev_mask_i) == '0) |-> !why_o.acc);

endmodule

// File: rtl/vhz_write_tracker.sv
module vhz_write_tracker
    import vhz_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   issue_valid_i,
    input  logic   stall_i,
    input  vmask_t dst_mask_i,
    output vmask_t prev_mask_o,
    output logic   recovering_o
);

    vmask_t prev_q;
    logic   rec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            rec_q  <= 1'b0;
        end else begin
            rec_q <= stall_i;
            if (!issue_valid_i) begin
                prev_q <= '0;
            end else if (!stall_i) begin
                prev_q <= dst_mask_i;
            end
        end
    end

    assign prev_mask_o  = prev_q;
    assign recovering_o = rec_q;

    // R8: a stall is never followed directly by another stall
    p_single_bubble_r8: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> !stall_i);

    // R8: the stall cycle leaves the recorded write set untouched
    p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> $stable(prev_q));

    // R10: an idle cycle empties the write set
    p_idle_clears_r10: assert property (@(posedge clk) disable iff (rst)
        !issue_valid_i |=> (prev_q == '0));

    // R4: a clean issue records exactly its destination mask
    p_record_dst_r4: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_i && !stall_i) |=> (prev_q == $past(dst_mask_i)));

endmodule

// File: rtl/vhz_interlock.sv
module vhz_interlock
    import vhz_pkg::*;
#(
    parameter int NUM_SRC = 4,
    localparam int IDX_BITS  = NUM_SRC * REG_W,
    localparam int ROLE_BITS = NUM_SRC * ROLE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue_valid_i,
    input  logic [IDX_BITS-1:0]  src_idx_i,
    input  logic [NUM_SRC-1:0]   src_pair_i,
    input  logic [ROLE_BITS-1:0] src_role_i,
    input  logic [VREGS-1:0]     dst_mask_i,
    output logic                 stall_o,
    output logic                 why_early_o,
    output logic                 why_acc_o
);

    src_op_t [NUM_SRC-1:0] ops;
    vmask_t     early_need;
    vmask_t     acc3_need;
    vmask_t     prev_mask;
    logic       recovering;
    stall_why_t why;
    logic       stall;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
        assign ops[g].idx  = src_idx_i[g*REG_W +: REG_W];
        assign ops[g].pair = src_pair_i[g];
        assign ops[g].role = src_role_e'(src_role_i[g*ROLE_W +: ROLE_W]);
    end

    vhz_src_decode #(
        .NUM_SRC (NUM_SRC)
    ) u_decode (
        .ops_i        (ops),
        .early_need_o (early_need),
        .acc3_need_o  (acc3_need)
    );

    vhz_hazard_eval u_eval (
        .clk           (clk),
        .rst           (rst),
        .issue_valid_i (issue_valid_i),
        .recovering_i  (recovering),
        .early_need_i  (early_need),
        .acc3_need_i   (acc3_need),
        .prev_mask_i   (prev_mask),
        .why_o         (why)
    );

    assign stall = why.early | why.acc;

    vhz_write_tracker u_track (
        .clk           (clk),
        .rst           (rst),
        .issue_valid_i (issue_valid_i),
        .stall_i       (stall),
        .dst_mask_i    (dst_mask_i),
        .prev_mask_o   (prev_mask),
        .recovering_o  (recovering)
    );

    assign stall_o     = stall;
    assign why_early_o = why.early;
    assign why_acc_o   = why.acc;

    // R8: the cycle after a stall issues the held packet without stalling
    p_reissue_clean_r8: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> !stall_o);

endmodule

// File: tb/test_vhz_interlock.sv
module test_vhz_interlock;

    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          issue_valid = 1'b0;
    logic [NS*5-1:0] src_idx  = '0;
    logic [NS-1:0]   src_pair = '0;
    logic [NS*3-1:0] src_role = '0;
    logic [31:0]   dst_mask = '0;
    logic          stall_o, why_early_o, why_acc_o;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_mask = '0;

    always #2 clk = ~clk;

    vhz_interlock #(.NUM_SRC(NS)) i_vhz_interlock (
        .clk           (clk),
        .rst           (rst),
        .issue_valid_i (issue_valid),
        .src_idx_i     (src_idx),
        .src_pair_i    (src_pair),
        .src_role_i    (src_role),
        .dst_mask_i    (dst_mask),
        .stall_o       (stall_o),
        .why_early_o   (why_early_o),
        .why_acc_o     (why_acc_o)
    );

    function automatic logic [31:0] cov(input logic [4:0] r, input logic p);
        logic [31:0] m;
        if (p) m = 32'h3 << {r[4:1], 1'b0};
        else   m = 32'h1 << r;
        return m;
    endfunction

    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s stall/early/acc actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Presents a packet (two configurable operands), checks it, and if a stall
    // is expected, checks the one-cycle reissue as well.
    task automatic run_pkt(input logic [4:0] r0, input logic p0, input logic [2:0] q0,
                           input logic [4:0] r1, input logic p1, input logic [2:0] q1,
                           input logic [31:0] dst, input string tag);
        logic e, a;
        logic [31:0] en, an;
        @(negedge clk);
        issue_valid = 1'b1;
        src_idx  = '0; src_pair = '0; src_role = '0;
        src_idx[4:0] = r0; src_pair[0] = p0; src_role[2:0] = q0;
        src_idx[9:5] = r1; src_pair[1] = p1; src_role[5:3] = q1;
        dst_mask = dst;
        en = ((q0 == 3'd2) ? cov(r0, p0) : 32'h0) | ((q1 == 3'd2) ? cov(r1, p1) : 32'h0);
        an = ((q0 == 3'd4) ? cov(r0, p0) : 32'h0) | ((q1 == 3'd4) ? cov(r1, p1) : 32'h0);
        e = (en & m_mask) != 0;
        a = (an & ~m_mask) != 0;
        #1;
        chk(tag, {stall_o, why_early_o, why_acc_o}, {e | a, e, a});
        @(posedge clk);
        if (e | a) begin
            @(negedge clk);
            #1;
            chk({tag, " R8 reissue"}, {stall_o, why_early_o, why_acc_o}, 3'b000);
            @(posedge clk);
        end
        m_mask = dst;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        issue_valid = 1'b0;
        #1;
        chk("R10 idle outputs", {stall_o, why_early_o, why_acc_o}, 3'b000);
        @(posedge clk);
        m_mask = '0;
    endtask

    initial begin : watchdog
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        string tg;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 in reset", {stall_o, why_early_o, why_acc_o}, 3'b000);
        rst = 1'b0;
        m_mask = '0;

        // R1: empty set after reset
        run_pkt(5'd3, 1'b0, 3'd2, 5'd0, 1'b0, 3'd0, 32'h0, "R1 early after reset");
        run_pkt(5'd9, 1'b0, 3'd4, 5'd0, 1'b0, 3'd0, 32'h0, "R1 acc3 after reset");

        // R4: intervening packet removes the early stall
        run_pkt(5'd0, 1'b0, 3'd0, 5'd0, 1'b0, 3'd0, 32'h1 << 8, "R4 producer");
        run_pkt(5'd0, 1'b0, 3'd0, 5'd0, 1'b0, 3'd0, 32'h1 << 1, "R4 spacer");
        run_pkt(5'd8, 1'b0, 3'd2, 5'd0, 1'b0, 3'd0, 32'h0, "R4 consumer no stall");

        // R2 / R8: back-to-back producer/early consumer
        run_pkt(5'd0, 1'b0, 3'd0, 5'd0, 1'b0, 3'd0, 32'h1, "R2 producer");
        run_pkt(5'd0, 1'b0, 3'd2, 5'd0, 1'b0, 3'd0, 32'h1 << 1, "R2 early hit");
        run_pkt(5'd1, 1'b0, 3'd2, 5'd0, 1'b0, 3'd0, 32'h0, "R8 after reissue set is dst");

        // R3: multiply-accumulate, accumulator just written, inputs not
        run_pkt(5'd0, 1'b0, 3'd0, 5'd0, 1'b0, 3'd0, 32'h1 << 8, "R3 producer");
        run_pkt(5'd2, 1'b0, 3'd2, 5'd8, 1'b0, 3'd3, 32'h1 << 8, "R3 plain acc no stall");

        // R6: constant-zero write then accumulate
        run_pkt(5'd0, 1'b0, 3'd0, 5'd0, 1'b0, 3'd0, 32'h1 << 24, "R6 zero V24");
        run_pkt(5'd24, 1'b0, 3'd4, 5'd2, 1'b0, 3'd1, 32'h1 << 24, "R6 acc3 satisfied");
        run_pkt(5'd18, 1'b0, 3'd4, 5'd0, 1'b0, 3'd0, 32'h1 << 18, "R5 acc3 other reg");

        // R9: both reasons at once
        run_pkt(5'd0, 1'b0, 3'd0, 5'd0, 1'b0, 3'd0, 32'h1 << 1, "R9 producer");
        run_pkt(5'd1, 1'b0, 3'd2, 5'd9, 1'b0, 3'd4, 32'h0, "R9 both reasons");

        // R10: idle cycle clears the set
        run_pkt(5'd0, 1'b0, 3'd0, 5'd0, 1'b0, 3'd0, 32'hFFFF_FFFF, "R10 producer all");
        idle_cycle();
        run_pkt(5'd5, 1'b0, 3'd2, 5'd0, 1'b0, 3'd0, 32'h0, "R10 early after idle");
        idle_cycle();
        run_pkt(5'd5, 1'b0, 3'd4, 5'd0, 1'b0, 3'd0, 32'h0, "R10 acc3 after idle");

        // Sweep: writer register x operand register x role x pair
        for (int w = 0; w < 32; w++) begin
            for (int r = 0; r < 32; r++) begin
                for (int q = 0; q < 8; q++) begin
                    for (int p = 0; p < 2; p++) begin
                        if (p == 1)       tg = "R7 sweep pair";
                        else if (q == 2)  tg = "R2 sweep early";
                        else if (q == 4)  tg = "R5 sweep acc3";
                        else              tg = "R3 sweep other role";
                        run_pkt(5'd0, 1'b0, 3'd0, 5'd0, 1'b0, 3'd0,
                                32'h1 << w, "R4 sweep prime");
                        run_pkt(r[4:0], p[0], q[2:0], 5'd0, 1'b0, 3'd0, 32'h0, tg);
                    end
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule